// File: doc/BRIEF.md
# Flash Program and Erase Timing Sequencer

This block times the program and erase operations of an embedded flash array. A host writes a divider once to bring the bus clock down to the flash timing clock, roughly 150 kHz to 200 kHz in a real system, then issues commands through a small register-style interface. Each command keeps the block busy for a fixed number of divided flash-clock periods. During that time the block drives abstract array strobes: a program strobe with address and data, or an erase strobe with the lowest and highest address to clear. Software never counts cycles. It waits for the busy flag to drop, or for the completion pulse.

Programming has two speeds. A lone byte program takes 9 flash periods. A burst-program command that arrives while another program is still running is held in a one-entry slot. It then starts as soon as the running one ends, takes only 4 periods, and busy does not drop in between. Erase comes in three forms: one page, the whole array, and the whole array except the first 1 KB, which keeps a boot region intact. A command that arrives at a moment it cannot be served sets an access-error flag and has no other effect.

Top module: `flash_seq`

## Requirements
- R1: Until the divider has been written once, every command is refused: acc_err goes high and busy stays low.
- R2: One flash period lasts div_val+1 bus cycles. A byte program (opcode 1) keeps busy high for exactly 9 flash periods, counted from the clock edge that accepts the command.
- R3: A burst program (opcode 2) accepted while idle lasts 9 periods. A burst program issued while a program (opcode 1 or 2) is running, with no other burst already waiting, extends busy without a gap by 4 periods. During those 4 periods arr_addr and arr_data carry the new command's values.
- R4: A page erase (opcode 3) lasts 4000 periods. It drives arr_erase with arr_lo equal to the command address with its low 9 bits cleared (512-byte pages) and arr_hi equal to arr_lo plus 511.
- R5: A mass erase (opcode 4) lasts 20000 periods, with arr_lo = 0 and arr_hi = 16383.
- R6: A boot-keeping mass erase (opcode 5) lasts 20000 periods, with arr_lo = 1024 and arr_hi = 16383.
- R7: Any other command issued while busy sets acc_err and is ignored. The running operation's length and array strobes are unchanged.
- R8: Opcodes 0, 6 and 7 set acc_err and start nothing.
- R9: done_flag rises on the edge where busy falls. done_flag and acc_err both clear when a command is accepted from idle.
- R10: When the interrupt is enabled, irq is high for exactly one cycle, the first idle cycle after an operation completes.
- R11: A divider write while busy is ignored. The running and the following operations keep the old divider.
- R12: While programming, arr_prog is high with arr_addr/arr_data equal to the command's values and arr_erase is low. After reset, busy, done_flag, acc_err, irq, arr_prog and arr_erase are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divider write strobe |
| div_val | input | 8 | Divider value; flash period = div_val+1 bus cycles |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 3 | Opcode: 1 byte program, 2 burst program, 3 page erase, 4 mass erase, 5 mass erase keeping first 1 KB |
| cmd_addr | input | 14 | Command byte address |
| cmd_data | input | 8 | Program data |
| busy | output | 1 | Operation in progress |
| done_flag | output | 1 | Sticky completion flag |
| acc_err | output | 1 | Sticky access-error flag |
| irq | output | 1 | One-cycle completion interrupt |
| arr_prog | output | 1 | Array program strobe |
| arr_erase | output | 1 | Array erase strobe |
| arr_addr | output | 14 | Program address |
| arr_data | output | 8 | Program data |
| arr_lo | output | 14 | Lowest address of the erase range |
| arr_hi | output | 14 | Highest address of the erase range |

## Verification
The hardest case to reach is a burst program landing inside the window of a running program. It has to arrive neither before the first command is accepted nor after busy has dropped. Arriving on the very finishing cycle is itself an edge. The stimulus injects a second command at a chosen cycle offset inside the measured busy window. The same mechanism drives an illegal command or a divider write into the middle of an erase. Each time, the whole busy interval is measured against the expected total.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_BURST     = 3'd2,
    OP_PAGE      = 3'd3,
    OP_MASS      = 3'd4,
    OP_MASS_KEEP = 3'd5
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/fsq_presc.sv
// Flash-clock tick generator: one tick every div+1 bus cycles while running.
module fsq_presc #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the phase counter never passes the divider while running
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));
endmodule

// File: rtl/fsq_timer.sv
// Counts remaining flash periods of the current operation.
module fsq_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             last
);
  logic [CNT_W-1:0] rem_q, rem_d;

  assign last = tick && (rem_q == CNT_W'(1));

  always_comb begin
    rem_d = rem_q;
    if (load)                      rem_d = load_val;
    else if (tick && rem_q != '0)  rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R2: a flash tick never arrives with no period left to count
  p_rem_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |-> (rem_q != '0));
endmodule

// File: rtl/fsq_ctrl.sv
// Command acceptance, burst slot, flags and array strobes.
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int AW      = 14,
  parameter int DW      = 8,
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 15,
  parameter int T_PROG  = 9,
  parameter int T_BURST = 4,
  parameter int T_PAGE  = 4000,
  parameter int T_MASS  = 20000,
  parameter int PAGE_B  = 512,
  parameter int PROT_B  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  input  logic             last,
  output logic             run,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [DIV_W-1:0] div_q,
  output logic             done_pulse,
  output logic             busy,
  output logic             done_flag,
  output logic             acc_err,
  output logic             arr_prog,
  output logic             arr_erase,
  output logic [AW-1:0]    arr_addr,
  output logic [DW-1:0]    arr_data,
  output logic [AW-1:0]    arr_lo,
  output logic [AW-1:0]    arr_hi
);
  localparam logic [AW-1:0] PMASK  = AW'(PAGE_B - 1);
  localparam logic [AW-1:0] PBASE  = AW'(PROT_B);
  localparam logic [AW-1:0] TOPADR = '1;

  st_e              st_q, st_d;
  op_e              cur_op_q, cur_op_d, op_in;
  logic [AW-1:0]    cur_addr_q, cur_addr_d, pend_addr_q, pend_addr_d;
  logic [DW-1:0]    cur_data_q, cur_data_d, pend_data_q, pend_data_d;
  logic             pend_q, pend_d;
  logic             div_ok_q, div_ok_d;
  logic [DIV_W-1:0] div_d;
  logic             done_q, done_d, err_q, err_d;
  logic             idle, op_legal, cur_is_prog, start_idle, chain_req, reject, fin;

  function automatic logic [CNT_W-1:0] dur(input op_e op);
    case (op)
      OP_PAGE:              dur = CNT_W'(T_PAGE);
      OP_MASS, OP_MASS_KEEP: dur = CNT_W'(T_MASS);
      default:              dur = CNT_W'(T_PROG);
    endcase
  endfunction

  assign op_in       = op_e'(cmd_op);
  assign idle        = (st_q == ST_IDLE);
  assign run         = !idle;
  assign op_legal    = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
  assign cur_is_prog = (cur_op_q == OP_PROG) || (cur_op_q == OP_BURST);
  assign start_idle  = cmd_we && idle && div_ok_q && op_legal;
  assign chain_req   = cmd_we && run && (op_in == OP_BURST) && cur_is_prog && !pend_q;
  assign reject      = cmd_we && !start_idle && !chain_req;
  assign fin         = run && last;
  assign done_pulse  = fin && !pend_q && !chain_req;

  always_comb begin
    st_d        = st_q;
    cur_op_d    = cur_op_q;
    cur_addr_d  = cur_addr_q;
    cur_data_d  = cur_data_q;
    pend_d      = pend_q;
    pend_addr_d = pend_addr_q;
    pend_data_d = pend_data_q;
    load        = 1'b0;
    load_val    = '0;
    if (start_idle) begin
      st_d       = ST_RUN;
      cur_op_d   = op_in;
      cur_addr_d = cmd_addr;
      cur_data_d = cmd_data;
      load       = 1'b1;
      load_val   = dur(op_in);
    end else if (fin) begin
      if (pend_q) begin
        cur_op_d   = OP_BURST;
        cur_addr_d = pend_addr_q;
        cur_data_d = pend_data_q;
        pend_d     = 1'b0;
        load       = 1'b1;
        load_val   = CNT_W'(T_BURST);
      end else if (chain_req) begin
        cur_op_d   = OP_BURST;
        cur_addr_d = cmd_addr;
        cur_data_d = cmd_data;
        load       = 1'b1;
        load_val   = CNT_W'(T_BURST);
      end else begin
        st_d = ST_IDLE;
      end
    end
    if (chain_req && !fin) begin
      pend_d      = 1'b1;
      pend_addr_d = cmd_addr;
      pend_data_d = cmd_data;
    end
  end

  always_comb begin
    done_d = done_q;
    if (start_idle)      done_d = 1'b0;
    else if (done_pulse) done_d = 1'b1;
    err_d = err_q;
    if (start_idle)  err_d = 1'b0;
    else if (reject) err_d = 1'b1;
    div_ok_d = div_ok_q;
    div_d    = div_q;
    if (div_we && idle) begin
      div_ok_d = 1'b1;
      div_d    = div_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_op_q    <= OP_NONE;
      cur_addr_q  <= '0;
      cur_data_q  <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      div_ok_q    <= 1'b0;
      div_q       <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      cur_op_q    <= cur_op_d;
      cur_addr_q  <= cur_addr_d;
      cur_data_q  <= cur_data_d;
      pend_q      <= pend_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
      div_ok_q    <= div_ok_d;
      div_q       <= div_d;
      done_q      <= done_d;
      err_q       <= err_d;
    end
  end

  assign busy      = run;
  assign done_flag = done_q;
  assign acc_err   = err_q;
  assign arr_prog  = run && cur_is_prog;
  assign arr_erase = run && (cur_op_q == OP_PAGE || cur_op_q == OP_MASS || cur_op_q == OP_MASS_KEEP);
  assign arr_addr  = cur_addr_q;
  assign arr_data  = cur_data_q;

  always_comb begin
    arr_lo = '0;
    arr_hi = '0;
    case (cur_op_q)
      OP_PAGE: begin
        arr_lo = cur_addr_q & ~PMASK;
        arr_hi = (cur_addr_q & ~PMASK) | PMASK;
      end
      OP_MASS: begin
        arr_lo = '0;
        arr_hi = TOPADR;
      end
      OP_MASS_KEEP: begin
        arr_lo = PBASE;
        arr_hi = TOPADR;
      end
      default: ;
    endcase
  end

  // R1: nothing runs before the divider has been set
  p_nodiv_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok_q |-> !busy);
  // R8: an undefined opcode always leaves the error flag raised
  p_badop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !op_legal) |=> acc_err);
  // R9: completion flag accompanies the fall of busy
  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
  // R4: erase range is never inverted
  p_range_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> (arr_lo <= arr_hi));
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW      = 14,
  parameter int DW      = 8,
  parameter int DIV_W   = 8,
  parameter int T_PROG  = 9,
  parameter int T_BURST = 4,
  parameter int T_PAGE  = 4000,
  parameter int T_MASS  = 20000,
  parameter int PAGE_B  = 512,
  parameter int PROT_B  = 1024,
  parameter bit IRQ_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  output logic             busy,
  output logic             done_flag,
  output logic             acc_err,
  output logic             irq,
  output logic             arr_prog,
  output logic             arr_erase,
  output logic [AW-1:0]    arr_addr,
  output logic [DW-1:0]    arr_data,
  output logic [AW-1:0]    arr_lo,
  output logic [AW-1:0]    arr_hi
);
  localparam int CNT_W = $clog2(T_MASS + 1);

  logic             run, load, tick, last, done_pulse;
  logic [CNT_W-1:0] load_val;
  logic [DIV_W-1:0] div_q;

  fsq_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  fsq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .tick(tick), .last(last)
  );

  fsq_ctrl #(
    .AW(AW), .DW(DW), .DIV_W(DIV_W), .CNT_W(CNT_W),
    .T_PROG(T_PROG), .T_BURST(T_BURST), .T_PAGE(T_PAGE), .T_MASS(T_MASS),
    .PAGE_B(PAGE_B), .PROT_B(PROT_B)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
    .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .last(last), .run(run), .load(load), .load_val(load_val), .div_q(div_q),
    .done_pulse(done_pulse), .busy(busy), .done_flag(done_flag), .acc_err(acc_err),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_lo(arr_lo), .arr_hi(arr_hi)
  );

  generate
    if (IRQ_EN) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= done_pulse;
      end
      assign irq = irq_q;
    end else begin : g_noirq
      assign irq = 1'b0;
    end
  endgenerate

  // R10: interrupt is a single-cycle pulse
  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10: interrupt only appears once the sequencer is idle
  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

// File: tb/test_flash_seq.sv
module test_flash_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        div_we;
  logic [7:0]  div_val;
  logic        cmd_we;
  logic [2:0]  cmd_op;
  logic [13:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        busy, done_flag, acc_err, irq, arr_prog, arr_erase;
  logic [13:0] arr_addr, arr_lo, arr_hi;
  logic [7:0]  arr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_seq i_flash_seq (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
    .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy(busy), .done_flag(done_flag), .acc_err(acc_err), .irq(irq),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_lo(arr_lo), .arr_hi(arr_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int periods(input int op);
    case (op)
      1, 2:    periods = 9;
      3:       periods = 4000;
      4, 5:    periods = 20000;
      default: periods = 0;
    endcase
  endfunction

  function automatic int exp_len(input int op, input int dv);
    exp_len = periods(op) * (dv + 1);
  endfunction

  task automatic set_div(input int dv);
    @(negedge clk);
    div_we = 1'b1; div_val = 8'(dv);
    @(negedge clk);
    div_we = 1'b0;
  endtask

  // Issue a command, optionally inject a second command or a divider
  // write at busy cycle k, and measure the busy interval.
  task automatic run_op(input int op, input int a, input int d,
                        input bit inj, input bit inj_div, input int k,
                        input int op2, input int a2, input int d2,
                        output int len, output int la, output int ld,
                        output int llo, output int lhi, output bit d0,
                        output bit irq_ok, output bit prog_ok);
    @(negedge clk);
    cmd_we = 1'b1; cmd_op = 3'(op); cmd_addr = 14'(a); cmd_data = 8'(d);
    @(negedge clk);
    cmd_we = 1'b0;
    len = 0; la = 0; ld = 0; llo = 0; lhi = 0; prog_ok = 1'b1;
    d0 = done_flag;
    while (busy) begin
      len++;
      la = int'(arr_addr); ld = int'(arr_data);
      llo = int'(arr_lo); lhi = int'(arr_hi);
      if ((op == 1 || op == 2) && !(arr_prog && !arr_erase)) prog_ok = 1'b0;
      cmd_we = 1'b0; div_we = 1'b0;
      if (inj && len == k) begin
        cmd_we = 1'b1; cmd_op = 3'(op2); cmd_addr = 14'(a2); cmd_data = 8'(d2);
      end
      if (inj_div && len == k) begin
        div_we = 1'b1; div_val = 8'd7;
      end
      @(negedge clk);
    end
    cmd_we = 1'b0; div_we = 1'b0;
    irq_ok = irq;
    @(negedge clk);
    irq_ok = irq_ok && !irq;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len, la, ld, llo, lhi, seed;
    bit d0, iok, pok;
    rst_n = 1'b0; div_we = 1'b0; div_val = '0;
    cmd_we = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done_flag && !acc_err && !irq && !arr_prog && !arr_erase, "R12 reset",
        int'({busy, done_flag, acc_err, irq, arr_prog, arr_erase}), 0);

    // R1: command before divider write
    run_op(1, 5, 5, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == 0, "R1 no start", len, 0);
    chk(acc_err == 1'b1, "R1 acc_err", int'(acc_err), 1);

    // R2 / R9 / R10 / R12: byte program at divider 0
    set_div(0);
    run_op(1, 14'h123, 8'hA5, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(1, 0), "R2 prog div0", len, exp_len(1, 0));
    chk(acc_err == 1'b0, "R9 err cleared", int'(acc_err), 0);
    chk(done_flag == 1'b1, "R9 done set", int'(done_flag), 1);
    chk(iok, "R10 irq pulse", int'(iok), 1);
    chk(pok && la == 14'h123 && ld == 8'hA5, "R12 prog strobes", la, 14'h123);

    // R9: done cleared at accept
    run_op(1, 1, 1, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(d0 == 1'b0, "R9 done cleared", int'(d0), 0);

    // R2: divider 2
    set_div(2);
    run_op(1, 7, 9, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(1, 2), "R2 prog div2", len, exp_len(1, 2));

    // R3: burst from idle, then chained burst
    set_div(1);
    run_op(2, 40, 3, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(2, 1), "R3 burst idle", len, exp_len(2, 1));
    run_op(1, 50, 8'h11, 1, 0, 3, 2, 51, 8'h22, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == 13 * 2, "R3 chained len", len, 26);
    chk(la == 51 && ld == 8'h22, "R3 chained addr", la, 51);
    chk(acc_err == 1'b0, "R3 no error", int'(acc_err), 0);

    // R7 / R4: page erase with an illegal mid-run program
    set_div(0);
    run_op(3, 14'h0A10, 0, 1, 0, 5, 1, 14'h3FF, 8'h77, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(3, 0), "R7 length kept", len, exp_len(3, 0));
    chk(llo == 14'h0A00 && lhi == 14'h0BFF, "R4 page range", llo, 14'h0A00);
    chk(acc_err == 1'b1, "R7 acc_err", int'(acc_err), 1);

    // R8: undefined opcodes
    run_op(6, 0, 0, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == 0 && acc_err, "R8 op6", len, 0);
    run_op(1, 2, 2, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    run_op(0, 0, 0, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == 0 && acc_err, "R8 op0", len, 0);

    // R11: divider write while busy is ignored
    run_op(1, 3, 3, 0, 1, 4, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(1, 0), "R11 running", len, exp_len(1, 0));
    run_op(1, 3, 3, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(1, 0), "R11 following", len, exp_len(1, 0));

    // R5 / R6: mass erases
    run_op(4, 100, 0, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(4, 0), "R5 mass len", len, exp_len(4, 0));
    chk(llo == 0 && lhi == 16383, "R5 mass range", llo, 0);
    run_op(5, 100, 0, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
    chk(len == exp_len(5, 0), "R6 keep len", len, exp_len(5, 0));
    chk(llo == 1024 && lhi == 16383, "R6 keep range", llo, 1024);

    // Random mix: R2 R3 R4
    for (int i = 0; i < 10; i++) begin
      int op, dv, a, d;
      op = 1 + int'($urandom % 3);
      dv = (op == 3) ? 0 : int'($urandom % 3);
      a  = int'($urandom % 16384);
      d  = int'($urandom % 256);
      set_div(dv);
      run_op(op, a, d, 0, 0, 0, 0, 0, 0, len, la, ld, llo, lhi, d0, iok, pok);
      chk(len == exp_len(op, dv), "R2 random len", len, exp_len(op, dv));
      if (op == 3)
        chk(llo == (a & 14'h3E00) && lhi == ((a & 14'h3E00) | 511), "R4 random range",
            llo, a & 14'h3E00);
      else
        chk(pok && la == a && ld == d, "R3 random strobes", la, a);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule